// File: doc/BRIEF.md
# Instruction-Paced Cycle Counter with Compare Timers

This block keeps a 32-bit count that moves forward by one each time the core signals that an instruction is about to execute. Up to three compare registers sit beside the counter. Each time the counter takes a new value, every compare register in use is checked for exact equality against that new value. A hit raises that comparator's timer interrupt line. The line then stays up while the counter keeps moving, and only a software write to the same compare register drops it.

Software can load the counter and each compare register through simple write strobes. A load of the counter wins over an advance in the same cycle, and the loaded value is checked against the compare registers just as an advanced value would be. A parameter table assigns each comparator an index on a wider interrupt vector. That vector feeds a separate priority controller, which is not part of this block.

Top module: `cyc_timer_top`

## Requirements
- R1: After reset the counter reads 0, every compare register holds 0, and all per-comparator lines and routed interrupt lines are low.
- R2: A cycle with `step_i` high and no counter write raises `count_o` by exactly one at the next clock edge. A cycle with neither leaves it unchanged.
- R3: The counter wraps from 0xFFFFFFFF to 0. A compare register holding 0 hits on that wrap.
- R4: When `cnt_we_i` and `step_i` are both high, the counter takes `cnt_wdata_i` and not an incremented value. The written value is checked against the compare registers.
- R5: When the counter takes a new value equal to a comparator's compare register, bit i of `tmr_irq_o` for that comparator i goes high at the same clock edge.
- R6: Once raised, a comparator line stays high while the counter keeps advancing past the compare value.
- R7: A comparison is made only when the counter is updated. Writing a compare register with the counter's current value while the counter holds does not raise the line.
- R8: A write to compare register i (`cmp_we_i` high, `cmp_sel_i` = i) stores `cmp_wdata_i` and drops line i at the next edge. The write wins over a hit on the old value in the same cycle.
- R9: Comparators act independently: a hit or a write on one leaves the other lines unchanged.
- R10: `irq_o[k]` is the OR of every comparator line whose table entry in `CMP_MAP` equals k. The default table sends comparator 0 to index 2, comparator 1 to index 5 and comparator 2 to index 6. All other indices stay low.
- R11: A compare write with `cmp_sel_i` at or above `NUM_CMP` changes no compare register and no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Instruction advance strobe |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 32 | Counter write value |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_sel_i | input | 2 | Compare register select |
| cmp_wdata_i | input | 32 | Compare register write value |
| count_o | output | 32 | Current counter value |
| tmr_irq_o | output | NUM_CMP | Sticky per-comparator timer lines |
| irq_o | output | NUM_IRQ | Timer lines routed to interrupt indices |

## Verification
The bench uses the default parameters: three comparators, an eight-wide interrupt vector and the table 0→2, 1→5, 2→6. With three comparators in use, a select value of 3 is the one out-of-range encoding, so R11 can be reached. Because the three routed indices are distinct and sparse, every line's route can be seen on its own, and combinations can be seen together on `irq_o`. Loading the counter near the top of its range brings the wrap and the zero-value hit into reach within a few cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_CNT_W = 32;
  localparam int TMR_MAX_CMP = 3;
  localparam int TMR_SEL_W = 2;

  typedef logic [TMR_CNT_W-1:0] tmr_cnt_t;

  // Next counter value: a software load wins over the advance strobe.
  function automatic tmr_cnt_t cnt_advance(input tmr_cnt_t cur, input logic step,
                                           input logic load, input tmr_cnt_t load_val);
    tmr_cnt_t nxt;
    if (load) nxt = load_val;
    else if (step) nxt = cur + tmr_cnt_t'(1);
    else nxt = cur;
    return nxt;
  endfunction

  // Compare check: only meaningful when the counter was updated.
  function automatic logic cmp_hit(input logic upd, input tmr_cnt_t nxt, input tmr_cnt_t cmpv);
    return upd && (nxt == cmpv);
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step_i,
  input  logic     load_i,
  input  tmr_cnt_t load_val_i,
  output tmr_cnt_t cnt_o,
  output tmr_cnt_t cnt_next_o,
  output logic     upd_o
);
  tmr_cnt_t cnt_q;

  assign cnt_next_o = cnt_advance(cnt_q, step_i, load_i, load_val_i);
  assign upd_o      = step_i | load_i;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next_o;
  end

  assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (cnt_q == $past(cnt_q) + tmr_cnt_t'(1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(cnt_q));

  assert_load_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/tmr_comparator.sv
module tmr_comparator
  import tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd_i,
  input  tmr_cnt_t cnt_next_i,
  input  logic     wr_i,
  input  tmr_cnt_t wdata_i,
  output logic     irq_o,
  output logic     hit_o
);
  tmr_cnt_t cmp_q;
  logic     irq_q;

  assign hit_o = cmp_hit(upd_i, cnt_next_i, cmp_q);
  assign irq_o = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else if (wr_i) begin
      cmp_q <= wdata_i;
      irq_q <= 1'b0;
    end else if (hit_o) begin
      irq_q <= 1'b1;
    end
  end

  assert_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && (cnt_next_i == cmp_q) && !wr_i) |=> irq_q);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !wr_i) |=> irq_q);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (!irq_q && cmp_q == $past(wdata_i)));

  assert_no_check_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && !irq_q) |=> !irq_q);
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route #(
  parameter int NUM_CMP = 3,
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = 3,
  parameter logic [NUM_CMP*IDX_W-1:0] CMP_MAP = '0
) (
  input  logic [NUM_CMP-1:0] tmr_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    always_comb begin
      irq_o[k] = 1'b0;
      for (int c = 0; c < NUM_CMP; c++) begin
        if (int'(CMP_MAP[c*IDX_W +: IDX_W]) == k) irq_o[k] = irq_o[k] | tmr_i[c];
      end
    end
  end

  always_comb begin
    assert_route_count_R10: assert ($countones(irq_o) <= $countones(tmr_i));
  end
endmodule

// File: rtl/cyc_timer_top.sv
module cyc_timer_top
  import tmr_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = $clog2(NUM_IRQ),
  parameter logic [NUM_CMP*IDX_W-1:0] CMP_MAP = {3'd6, 3'd5, 3'd2}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic                 cnt_we_i,
  input  logic [31:0]          cnt_wdata_i,
  input  logic                 cmp_we_i,
  input  logic [1:0]           cmp_sel_i,
  input  logic [31:0]          cmp_wdata_i,
  output logic [31:0]          count_o,
  output logic [NUM_CMP-1:0]   tmr_irq_o,
  output logic [NUM_IRQ-1:0]   irq_o
);
  tmr_cnt_t cnt_next;
  logic     cnt_upd;
  logic [NUM_CMP-1:0] cmp_wr;
  logic [NUM_CMP-1:0] cmp_hit_ev;

  tmr_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .load_i     (cnt_we_i),
    .load_val_i (cnt_wdata_i),
    .cnt_o      (count_o),
    .cnt_next_o (cnt_next),
    .upd_o      (cnt_upd)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign cmp_wr[i] = cmp_we_i && (cmp_sel_i == TMR_SEL_W'(i));
    tmr_comparator u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_i      (cnt_upd),
      .cnt_next_i (cnt_next),
      .wr_i       (cmp_wr[i]),
      .wdata_i    (cmp_wdata_i),
      .irq_o      (tmr_irq_o[i]),
      .hit_o      (cmp_hit_ev[i])
    );
  end

  tmr_irq_route #(
    .NUM_CMP (NUM_CMP),
    .NUM_IRQ (NUM_IRQ),
    .IDX_W   (IDX_W),
    .CMP_MAP (CMP_MAP)
  ) u_route (
    .tmr_i (tmr_irq_o),
    .irq_o (irq_o)
  );

  // Lines change only through a hit or a write on their own comparator.
  assert_indep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr == '0 && cmp_hit_ev == '0) |=> $stable(tmr_irq_o));

  assert_bad_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we_i && int'(cmp_sel_i) >= NUM_CMP && cmp_hit_ev == '0) |=> $stable(tmr_irq_o));
endmodule

// File: tb/tb_cyc_timer_top.sv
module tb_cyc_timer_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b0, cnt_we_i = 1'b0, cmp_we_i = 1'b0;
  logic [31:0] cnt_wdata_i = '0, cmp_wdata_i = '0;
  logic [1:0] cmp_sel_i = '0;
  logic [31:0] count_o;
  logic [2:0] tmr_irq_o;
  logic [7:0] irq_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cyc_timer_top dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .cnt_we_i(cnt_we_i),
    .cnt_wdata_i(cnt_wdata_i), .cmp_we_i(cmp_we_i), .cmp_sel_i(cmp_sel_i),
    .cmp_wdata_i(cmp_wdata_i), .count_o(count_o), .tmr_irq_o(tmr_irq_o), .irq_o(irq_o)
  );

  // Bench view of the routing table: comparator 0->2, 1->5, 2->6.
  function automatic logic [7:0] route(input logic [2:0] t);
    return {1'b0, t[2], t[1], 2'b00, t[0], 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one cycle and returns at the next negedge.
  task automatic tick(input logic st, input logic cwe, input logic [31:0] cwd,
                      input logic mwe, input logic [1:0] msel, input logic [31:0] mwd);
    step_i = st; cnt_we_i = cwe; cnt_wdata_i = cwd;
    cmp_we_i = mwe; cmp_sel_i = msel; cmp_wdata_i = mwd;
    @(negedge clk);
    step_i = 0; cnt_we_i = 0; cmp_we_i = 0;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) tick(1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk("R1 count", count_o, 0);
    chk("R1 tmr", {29'd0, tmr_irq_o}, 0);
    chk("R1 irq", {24'd0, irq_o}, 0);
  endtask

  task automatic t_increment;
    steps(5);
    chk("R2 five steps", count_o, 5);
    tick(0, 0, 0, 0, 0, 0);
    chk("R2 hold", count_o, 5);
  endtask

  task automatic t_match_sticky;
    tick(0, 0, 0, 1, 2'd0, 32'd10);
    steps(4);
    chk("R5 before match", {29'd0, tmr_irq_o}, 0);
    steps(1);
    chk("R5 count", count_o, 10);
    chk("R5 match", {29'd0, tmr_irq_o}, 3'b001);
    chk("R10 route c0", {24'd0, irq_o}, {24'd0, route(3'b001)});
    steps(1);
    chk("R6 sticky", {29'd0, tmr_irq_o}, 3'b001);
    tick(0, 0, 0, 1, 2'd0, 32'd100);
    chk("R8 clear", {29'd0, tmr_irq_o}, 0);
    chk("R8 irq low", {24'd0, irq_o}, 0);
  endtask

  task automatic t_no_update;
    tick(0, 0, 0, 1, 2'd1, 32'd11);   // counter already 11
    tick(0, 0, 0, 0, 0, 0);
    chk("R7 no check without update", {29'd0, tmr_irq_o}, 0);
  endtask

  task automatic t_write_prio;
    tick(0, 0, 0, 1, 2'd2, 32'd50);
    tick(1, 1, 32'd50, 0, 0, 0);
    chk("R4 load wins", count_o, 50);
    chk("R4 loaded value checked", {29'd0, tmr_irq_o}, 3'b100);
    chk("R9 others untouched", {29'd0, tmr_irq_o[1:0]}, 0);
    chk("R10 route c2", {24'd0, irq_o}, {24'd0, route(3'b100)});
    tick(0, 0, 0, 1, 2'd3, 32'd0);
    chk("R11 bad select ignored", {29'd0, tmr_irq_o}, 3'b100);
  endtask

  task automatic t_clear_vs_hit;
    tick(0, 1, 32'd10, 0, 0, 0);
    tick(1, 0, 0, 1, 2'd1, 32'd77);   // 11 would hit old compare 11
    chk("R8 write beats hit", {29'd0, tmr_irq_o}, 3'b100);
    tick(0, 1, 32'd76, 0, 0, 0);
    steps(1);
    chk("R8 new value stored", {29'd0, tmr_irq_o}, 3'b110);
    chk("R10 route c1+c2", {24'd0, irq_o}, {24'd0, route(3'b110)});
  endtask

  task automatic t_wrap;
    tick(0, 0, 0, 1, 2'd2, 32'd5);
    tick(0, 0, 0, 1, 2'd1, 32'd5);
    tick(0, 0, 0, 1, 2'd0, 32'd0);
    chk("R9 all cleared", {29'd0, tmr_irq_o}, 0);
    tick(0, 1, 32'hFFFF_FFFE, 0, 0, 0);
    steps(1);
    chk("R3 top value", count_o, 32'hFFFF_FFFF);
    chk("R3 no early hit", {29'd0, tmr_irq_o}, 0);
    steps(1);
    chk("R3 wrap", count_o, 0);
    chk("R3 zero hit", {29'd0, tmr_irq_o}, 3'b001);
  endtask

  initial begin
    #200_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_increment();
    t_match_sticky();
    t_no_update();
    t_write_prio();
    t_clear_vs_hit();
    t_wrap();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule